// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns an instruction's 6-bit operation field and 6-bit function field into the control levels that steer a single-cycle processor datapath. Fourteen instructions are recognised: the register-register operations add, sub, and, or and slt, the immediate operations addi, andi, ori and slti, the word load and store, the two conditional branches and the unconditional jump. It is purely combinational. The outputs follow the current inputs with no clock and no stored state.

The block has two stages of decoding. The first stage looks only at the operation field. It produces the destination select, the register write enable, the immediate extension mode, the second-operand select, the memory strobes, the write-back source and the three flow-change flags. It also selects which ALU operation to use. For register-register instructions, the second stage reads the function field to choose the ALU operation. For all other instructions, the operation field alone fixes the ALU operation. Every output has a defined value for every input, including outputs the datapath ignores and input codes that are not recognised. This means a downstream checker can compare all outputs exactly.

Top module: `ctl_decoder_top`

## Requirements
- R1: Operation field 000000 (register-register) gives dst_rd=1, opb_imm=0, wb_mem=0 and ext_signed=0. mem_rd, mem_wr, take_eq, take_ne and jump are all 0. reg_we=1 when the function code is recognised.
- R2: For operation field 000000, alu_op follows the function field: 100000 gives 0010 (add), 100010 gives 0110 (sub), 100100 gives 0000 (and), 100101 gives 0001 (or) and 101010 gives 0111 (slt).
- R3: For operation field 000000 with any other function code, reg_we=0 and alu_op=0010. All other outputs take the R1 values.
- R4: The immediate operations addi 001000, andi 001100, ori 001101 and slti 001010 give dst_rd=0, opb_imm=1 and reg_we=1, with no memory access, no flow change and wb_mem=0. Their alu_op is 0010, 0000, 0001 and 0111 respectively. For these opcodes the function field has no effect.
- R5: ext_signed=1 for addi, slti, load, store, beq and bne. ext_signed=0 for andi, ori, register-register, jump and unrecognised opcodes.
- R6: Load 100011 gives reg_we=1, dst_rd=0, opb_imm=1, mem_rd=1, mem_wr=0, wb_mem=1 and alu_op=0010.
- R7: Store 101011 gives mem_wr=1, mem_rd=0, reg_we=0, opb_imm=1 and alu_op=0010. The unused selects dst_rd and wb_mem are held at 0.
- R8: beq 000100 gives take_eq=1 and bne 000101 gives take_ne=1. Both give opb_imm=0 and alu_op=0110, and no register or memory write.
- R9: Jump 000010 gives jump=1. All other single-bit controls are 0 and alu_op=0010.
- R10: Any other operation field drives every single-bit control to 0 and alu_op to 0010.
- R11: mem_rd and mem_wr are never both 1. At most one of take_eq, take_ne and jump is 1. A flow-change flag never coincides with a register or memory write.
- R12: The outputs settle to the new decode in the same cycle that the inputs change. No clock edge is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Operation field of the instruction |
| fn_code | input | 6 | Function field of the instruction |
| dst_rd | output | 1 | 1: write destination comes from the rd field, 0: from the rt field |
| reg_we | output | 1 | Register file write enable |
| ext_signed | output | 1 | 1: sign-extend the 16-bit immediate, 0: zero-extend it |
| opb_imm | output | 1 | 1: second ALU operand is the extended immediate, 0: the second register |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| wb_mem | output | 1 | 1: write-back data comes from memory, 0: from the ALU |
| take_eq | output | 1 | Branch-if-equal flag |
| take_ne | output | 1 | Branch-if-not-equal flag |
| jump | output | 1 | Unconditional jump flag |
| alu_op | output | 4 | ALU operation code |

## Verification
The assertions check the R11 exclusivity rules against the opcode decode output on every input change. They also check that a load always pairs its read strobe with a register write from memory, and that the ALU stage only ever emits one of its five legal codes. The exact value of each control for each instruction cannot be checked that way. That includes the defined fillers for ignored outputs, the quiet response to unrecognised codes and the fact that the function field is ignored outside register-register instructions. Only the bench's directed vectors and its sweeps over all 64 operation codes and all 64 function codes show those.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int OP_W  = 6;
    localparam int FN_W  = 6;
    localparam int ALU_W = 4;

    // operation field codes
    localparam logic [OP_W-1:0] OPC_REG  = 6'b000000;
    localparam logic [OP_W-1:0] OPC_JMP  = 6'b000010;
    localparam logic [OP_W-1:0] OPC_BEQ  = 6'b000100;
    localparam logic [OP_W-1:0] OPC_BNE  = 6'b000101;
    localparam logic [OP_W-1:0] OPC_ADDI = 6'b001000;
    localparam logic [OP_W-1:0] OPC_SLTI = 6'b001010;
    localparam logic [OP_W-1:0] OPC_ANDI = 6'b001100;
    localparam logic [OP_W-1:0] OPC_ORI  = 6'b001101;
    localparam logic [OP_W-1:0] OPC_LOAD = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STOR = 6'b101011;

    // function field codes
    localparam logic [FN_W-1:0] FNC_ADD = 6'b100000;
    localparam logic [FN_W-1:0] FNC_SUB = 6'b100010;
    localparam logic [FN_W-1:0] FNC_AND = 6'b100100;
    localparam logic [FN_W-1:0] FNC_OR  = 6'b100101;
    localparam logic [FN_W-1:0] FNC_SLT = 6'b101010;

    // ALU operation codes
    localparam logic [ALU_W-1:0] AOP_AND = 4'b0000;
    localparam logic [ALU_W-1:0] AOP_OR  = 4'b0001;
    localparam logic [ALU_W-1:0] AOP_ADD = 4'b0010;
    localparam logic [ALU_W-1:0] AOP_SUB = 4'b0110;
    localparam logic [ALU_W-1:0] AOP_SLT = 4'b0111;

    typedef enum logic [2:0] {
        SEL_ADD,
        SEL_SUB,
        SEL_AND,
        SEL_OR,
        SEL_SLT,
        SEL_FUNCT
    } alu_sel_e;

    typedef struct packed {
        logic dst_rd;
        logic reg_we;
        logic ext_signed;
        logic opb_imm;
        logic mem_rd;
        logic mem_wr;
        logic wb_mem;
        logic take_eq;
        logic take_ne;
        logic jump;
    } ctl_word_t;

    localparam ctl_word_t CTL_IDLE = '0;

    function automatic logic [ALU_W-1:0] sel_to_code(input alu_sel_e s);
        case (s)
            SEL_SUB: return AOP_SUB;
            SEL_AND: return AOP_AND;
            SEL_OR:  return AOP_OR;
            SEL_SLT: return AOP_SLT;
            default: return AOP_ADD;
        endcase
    endfunction

    function automatic logic is_legal_aop(input logic [ALU_W-1:0] c);
        return (c == AOP_ADD) || (c == AOP_SUB) || (c == AOP_AND) ||
               (c == AOP_OR)  || (c == AOP_SLT);
    endfunction

endpackage

// File: rtl/ctl_opcode_dec.sv
module ctl_opcode_dec
    import ctl_pkg::*;
#(
    parameter int OPW = OP_W
) (
    input  logic [OPW-1:0] op_code,
    output ctl_word_t      ctl,
    output alu_sel_e       alu_sel
);

    always_comb begin
        ctl     = CTL_IDLE;
        alu_sel = SEL_ADD;
        case (op_code)
            OPC_REG: begin
                ctl.dst_rd = 1'b1;
                ctl.reg_we = 1'b1;
                alu_sel    = SEL_FUNCT;
            end
            OPC_ADDI, OPC_SLTI, OPC_ANDI, OPC_ORI: begin
                ctl.reg_we     = 1'b1;
                ctl.opb_imm    = 1'b1;
                ctl.ext_signed = (op_code == OPC_ADDI) || (op_code == OPC_SLTI);
                case (op_code)
                    OPC_SLTI: alu_sel = SEL_SLT;
                    OPC_ANDI: alu_sel = SEL_AND;
                    OPC_ORI:  alu_sel = SEL_OR;
                    default:  alu_sel = SEL_ADD;
                endcase
            end
            OPC_LOAD: begin
                ctl.reg_we     = 1'b1;
                ctl.ext_signed = 1'b1;
                ctl.opb_imm    = 1'b1;
                ctl.mem_rd     = 1'b1;
                ctl.wb_mem     = 1'b1;
            end
            OPC_STOR: begin
                ctl.ext_signed = 1'b1;
                ctl.opb_imm    = 1'b1;
                ctl.mem_wr     = 1'b1;
            end
            OPC_BEQ, OPC_BNE: begin
                ctl.ext_signed = 1'b1;
                ctl.take_eq    = (op_code == OPC_BEQ);
                ctl.take_ne    = (op_code == OPC_BNE);
                alu_sel        = SEL_SUB;
            end
            OPC_JMP: begin
                ctl.jump = 1'b1;
            end
            default: begin
                ctl     = CTL_IDLE;
                alu_sel = SEL_ADD;
            end
        endcase
    end

    // checks on the decoded control word
    always_comb begin
        assert_mem_excl_R11: assert (!(ctl.mem_rd && ctl.mem_wr))
            else $error("memory read and write strobes both set");
        assert_flow_onehot_R11: assert ($onehot0({ctl.take_eq, ctl.take_ne, ctl.jump}))
            else $error("more than one flow-change flag set");
        assert_flow_nowrite_R11: assert (!((ctl.take_eq || ctl.take_ne || ctl.jump) &&
                                           (ctl.reg_we || ctl.mem_wr || ctl.mem_rd)))
            else $error("flow change paired with a write");
        assert_load_path_R6: assert (!ctl.mem_rd || (ctl.reg_we && ctl.wb_mem && ctl.opb_imm))
            else $error("memory read without write-back from memory");
    end

endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
    import ctl_pkg::*;
#(
    parameter int FNW  = FN_W,
    parameter int AOPW = ALU_W
) (
    input  alu_sel_e        alu_sel,
    input  logic [FNW-1:0]  fn_code,
    output logic [AOPW-1:0] alu_op,
    output logic            fn_ok
);

    always_comb begin
        fn_ok  = 1'b1;
        alu_op = sel_to_code(alu_sel);
        if (alu_sel == SEL_FUNCT) begin
            case (fn_code)
                FNC_ADD: alu_op = AOP_ADD;
                FNC_SUB: alu_op = AOP_SUB;
                FNC_AND: alu_op = AOP_AND;
                FNC_OR:  alu_op = AOP_OR;
                FNC_SLT: alu_op = AOP_SLT;
                default: begin
                    alu_op = AOP_ADD;
                    fn_ok  = 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        assert_aop_legal_R2: assert (is_legal_aop(alu_op))
            else $error("illegal ALU operation code %b", alu_op);
        assert_fn_bad_only_reg_R3: assert (fn_ok || (alu_sel == SEL_FUNCT))
            else $error("function field rejected outside register-register");
    end

endmodule

// File: rtl/ctl_decoder_top.sv
module ctl_decoder_top
    import ctl_pkg::*;
(
    input  logic [5:0] op_code,
    input  logic [5:0] fn_code,
    output logic       dst_rd,
    output logic       reg_we,
    output logic       ext_signed,
    output logic       opb_imm,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       wb_mem,
    output logic       take_eq,
    output logic       take_ne,
    output logic       jump,
    output logic [3:0] alu_op
);

    ctl_word_t ctl;
    alu_sel_e  alu_sel;
    logic      fn_ok;

    ctl_opcode_dec #(.OPW(OP_W)) u_opdec (
        .op_code (op_code),
        .ctl     (ctl),
        .alu_sel (alu_sel)
    );

    ctl_alu_dec #(.FNW(FN_W), .AOPW(ALU_W)) u_aludec (
        .alu_sel (alu_sel),
        .fn_code (fn_code),
        .alu_op  (alu_op),
        .fn_ok   (fn_ok)
    );

    // an unrecognised function code cancels the register write (R3)
    assign dst_rd     = ctl.dst_rd;
    assign reg_we     = ctl.reg_we & fn_ok;
    assign ext_signed = ctl.ext_signed;
    assign opb_imm    = ctl.opb_imm;
    assign mem_rd     = ctl.mem_rd;
    assign mem_wr     = ctl.mem_wr;
    assign wb_mem     = ctl.wb_mem;
    assign take_eq    = ctl.take_eq;
    assign take_ne    = ctl.take_ne;
    assign jump       = ctl.jump;

endmodule

// File: tb/ctl_decoder_top_tb_top.sv
module ctl_decoder_top_tb_top;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [5:0] op_code, fn_code;
    logic dst_rd, reg_we, ext_signed, opb_imm, mem_rd, mem_wr, wb_mem;
    logic take_eq, take_ne, jump;
    logic [3:0] alu_op;

    ctl_decoder_top dut_i (
        .op_code(op_code), .fn_code(fn_code),
        .dst_rd(dst_rd), .reg_we(reg_we), .ext_signed(ext_signed),
        .opb_imm(opb_imm), .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_mem(wb_mem),
        .take_eq(take_eq), .take_ne(take_ne), .jump(jump), .alu_op(alu_op)
    );

    // {dst_rd, reg_we, ext_signed, opb_imm, mem_rd, mem_wr, wb_mem, eq, ne, j, alu_op}
    typedef struct {
        logic [13:0] exp;
        string       tag;
        logic [5:0]  op;
        logic [5:0]  fn;
    } item_t;

    item_t q[$];
    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    function automatic logic [13:0] model(input logic [5:0] op, input logic [5:0] fn);
        logic [3:0] a;
        case (op)
            6'b000000: begin
                case (fn)
                    6'b100000: return {7'b1100000, 3'b000, 4'b0010};
                    6'b100010: return {7'b1100000, 3'b000, 4'b0110};
                    6'b100100: return {7'b1100000, 3'b000, 4'b0000};
                    6'b100101: return {7'b1100000, 3'b000, 4'b0001};
                    6'b101010: return {7'b1100000, 3'b000, 4'b0111};
                    default:   return {7'b1000000, 3'b000, 4'b0010};
                endcase
            end
            6'b001000: return {7'b0111000, 3'b000, 4'b0010};
            6'b001010: return {7'b0111000, 3'b000, 4'b0111};
            6'b001100: return {7'b0101000, 3'b000, 4'b0000};
            6'b001101: return {7'b0101000, 3'b000, 4'b0001};
            6'b100011: return {7'b0111101, 3'b000, 4'b0010};
            6'b101011: return {7'b0011010, 3'b000, 4'b0010};
            6'b000100: return {7'b0010000, 3'b100, 4'b0110};
            6'b000101: return {7'b0010000, 3'b010, 4'b0110};
            6'b000010: return {7'b0000000, 3'b001, 4'b0010};
            default: begin
                a = 4'b0010;
                return {7'b0000000, 3'b000, a};
            end
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] op, input logic [5:0] fn);
        case (op)
            6'b000000: begin
                case (fn)
                    6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010: return "R1/R2";
                    default: return "R3";
                endcase
            end
            6'b001000, 6'b001010, 6'b001100, 6'b001101: return "R4/R5";
            6'b100011: return "R6";
            6'b101011: return "R7";
            6'b000100, 6'b000101: return "R8";
            6'b000010: return "R9";
            default: return "R10";
        endcase
    endfunction

    // driver: applies one input pair per cycle and queues its expectation
    task automatic drive(input logic [5:0] op, input logic [5:0] fn);
        item_t it;
        @(posedge clk);
        #2;
        op_code = op;
        fn_code = fn;
        it.exp = model(op, fn);
        it.tag = tag_of(op, fn);
        it.op  = op;
        it.fn  = fn;
        q.push_back(it);
    endtask

    // monitor: samples at the falling edge, same cycle as the input change (R12)
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                logic [13:0] act;
                it  = q.pop_front();
                act = {dst_rd, reg_we, ext_signed, opb_imm, mem_rd, mem_wr, wb_mem,
                       take_eq, take_ne, jump, alu_op};
                compared++;
                if (act !== it.exp) begin
                    mismatched++;
                    $display("FAIL %s R12 op=%b fn=%b actual=%b expected=%b",
                             it.tag, it.op, it.fn, act, it.exp);
                end
                // R11 checked at the ports too
                compared++;
                if ((mem_rd && mem_wr) || !$onehot0({take_eq, take_ne, jump}) ||
                    ((take_eq || take_ne || jump) && (reg_we || mem_wr))) begin
                    mismatched++;
                    $display("FAIL R11 op=%b actual=%b expected=exclusive controls", it.op, act);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        op_code = 6'b111111;
        fn_code = 6'b000000;
        // R1 R2: each function code
        drive(6'b000000, 6'b100000);
        drive(6'b000000, 6'b100010);
        drive(6'b000000, 6'b100100);
        drive(6'b000000, 6'b100101);
        drive(6'b000000, 6'b101010);
        // R3: unrecognised function codes
        drive(6'b000000, 6'b000000);
        drive(6'b000000, 6'b111111);
        // R4 R5: immediates, with function fields that must be ignored
        drive(6'b001000, 6'b100010);
        drive(6'b001010, 6'b100100);
        drive(6'b001100, 6'b101010);
        drive(6'b001101, 6'b100000);
        // R6 R7 R8 R9
        drive(6'b100011, 6'b000000);
        drive(6'b101011, 6'b100101);
        drive(6'b000100, 6'b000000);
        drive(6'b000101, 6'b100000);
        drive(6'b000010, 6'b101010);
        // R10: unknown opcodes
        drive(6'b111111, 6'b100000);
        drive(6'b000001, 6'b000000);
        // sweep every operation code with a varying function field
        for (int o = 0; o < 64; o++) drive(6'(o), 6'(o * 5));
        // sweep every function code under the register-register opcode
        for (int f = 0; f < 64; f++) drive(6'b000000, 6'(f));
        // back-to-back changes to show same-cycle response (R12)
        drive(6'b100011, 6'b000000);
        drive(6'b000000, 6'b100010);
        drive(6'b101011, 6'b000000);
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule